// File: doc/BRIEF.md
# Script Branch-Condition and Interrupt Unit

This block sits in the execute stage of a small script processor that runs a bus controller. It takes a decoded transfer-control instruction, works out whether the instruction's condition holds, and acts on the result. The condition source can be the ALU carry flag, the bus phase lines captured when the last request strobe arrived, the captured data byte, or phase and data together. One polarity bit then decides whether a match or a mismatch counts as taken.

Two opcodes have side effects. A halting interrupt stores the instruction's 32-bit address field as a service vector, pulls the active-low interrupt line and stops the core. The core stays stopped until the host writes the script pointer. An on-the-fly interrupt only sets a sticky status bit, which the host clears by writing a one, and execution goes on. Every other opcode only reports whether the fetch unit should use the branch target or the next sequential address. Target arithmetic, fetch and the ALU live elsewhere.

Instructions come in on a valid/ready stream. `instr_ready` is low while the core is halted. An instruction is accepted on a clock edge where both `instr_valid` and `instr_ready` are high. The producer must hold the word and address stable while it waits. The result is a one-cycle `sel_valid` pulse with no back-pressure. The fetch unit must take it in that cycle.

Top module: `script_branch_unit`

## Requirements
- R1: When word bit 21 (carry test) is 1, the match value is the carry input, and the phase and data compares are not used.
- R2: When bit 21 is 0 and bit 17 (phase compare) is 1, the phase field in word bits [26:24] must equal `phase_lat` for a match, but only when `initiator` is 1. When `initiator` is 0 the phase field and `phase_lat` have no effect.
- R3: When bit 21 is 0 and bit 18 (data compare) is 1, word bits [7:0] must equal `data_lat` for a match. With both compares enabled, both must hold.
- R4: With bits 21, 18 and 17 all 0, the match value is 1. Bit 19 (polarity) sets taken = match when 1 and taken = not match when 0.
- R5: One cycle after each accepted instruction, `sel_valid` pulses high for one cycle. `sel_taken` is 1 only when the instruction is taken and its opcode is not an interrupt. Opcode field bits [29:27]: 3 is the halting interrupt, 4 is the on-the-fly interrupt, anything else is a plain transfer. When `sel_taken` is 0, the fetch unit keeps the sequential pointer.
- R6: A taken halting interrupt sets `halted` and drops `instr_ready` from the next cycle. No further instruction is accepted until the halt is released.
- R7: A taken halting interrupt loads `instr_addr` into `int_vector` on the next cycle. `int_vector` is unchanged otherwise.
- R8: A `host_ptr_wr` pulse clears `halted` on the next edge, and `instr_ready` returns in the following cycle.
- R9: A taken on-the-fly interrupt sets `fly_status` on the next cycle and leaves `halted` at 0.
- R10: `fly_status` holds until a `host_fly_clr` pulse clears it. A new set in the same cycle wins over the clear.
- R11: `irq_n` is low exactly when `halted` or `fly_status` is set.
- R12: After reset, `halted`, `fly_status` and `sel_valid` are 0, `int_vector` is 0, `irq_n` is 1 and `instr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present |
| instr_ready | output | 1 | Unit can accept an instruction (low while halted) |
| instr_word | input | 32 | Decoded first instruction word |
| instr_addr | input | 32 | Instruction address field |
| carry | input | 1 | ALU carry flag |
| phase_lat | input | 3 | Phase lines captured at the request strobe |
| data_lat | input | 8 | Captured data byte |
| initiator | input | 1 | 1 = initiator mode, 0 = target mode |
| host_ptr_wr | input | 1 | Host wrote the script pointer |
| host_fly_clr | input | 1 | Host write-one-to-clear of the on-the-fly status |
| sel_valid | output | 1 | Pointer-select result valid |
| sel_taken | output | 1 | 1 = branch target, 0 = sequential pointer |
| irq_n | output | 1 | Interrupt request, active low |
| int_vector | output | 32 | Saved service vector |
| halted | output | 1 | Core halted by an interrupt |
| fly_status | output | 1 | On-the-fly interrupt status bit |

## Verification
Every result of this block shows up exactly one clock after its cause: `sel_valid`/`sel_taken`, the vector, the halt flag and the status bit follow one edge after the accept or the host write. `irq_n` and `instr_ready` follow those flags in the same cycle. The bench keeps a behavioural model that applies each accept and host write at the same rising edge as the design. It compares every output at the following falling edge, so each comparison falls in the cycle where the result is due. Stimulus changes only after that comparison.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned PH_W   = 3;
  parameter int unsigned DAT_W  = 8;

  localparam int unsigned OP_LSB   = 27;
  localparam int unsigned PH_LSB   = 24;
  localparam int unsigned CRY_BIT  = 21;
  localparam int unsigned POL_BIT  = 19;
  localparam int unsigned DCE_BIT  = 18;
  localparam int unsigned PCE_BIT  = 17;

  typedef enum logic [2:0] {
    OP_INT  = 3'd3,
    OP_FLY  = 3'd4
  } op_e;

  typedef struct packed {
    logic take;
    logic is_int;
    logic is_fly;
  } verdict_t;
endpackage

// File: rtl/sbu_cond_eval.sv
module sbu_cond_eval
  import sbu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              carry,
  input  logic [PH_W-1:0]   phase_lat,
  input  logic [DAT_W-1:0]  data_lat,
  input  logic              initiator,
  output verdict_t          verdict
);
  logic [PH_W-1:0]  ph_field;
  logic [DAT_W-1:0] dat_field;
  logic [2:0]       op_field;
  logic             ph_ok, dat_ok, match;

  always_comb begin
    ph_field  = word[PH_LSB +: PH_W];
    dat_field = word[DAT_W-1:0];
    op_field  = word[OP_LSB +: 3];
    // phase only counts in initiator mode
    ph_ok  = !(word[PCE_BIT] && initiator) || (ph_field == phase_lat);
    dat_ok = !word[DCE_BIT] || (dat_field == data_lat);
    match  = word[CRY_BIT] ? carry : (ph_ok && dat_ok);
    verdict.take   = word[POL_BIT] ? match : !match;
    verdict.is_int = (op_field == OP_INT);
    verdict.is_fly = (op_field == OP_FLY);
  end
endmodule

// File: rtl/sbu_int_ctrl.sv
module sbu_int_ctrl
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  verdict_t          verdict,
  input  logic [ADDR_W-1:0] addr,
  input  logic              host_ptr_wr,
  input  logic              host_fly_clr,
  output logic              sel_valid,
  output logic              sel_taken,
  output logic [ADDR_W-1:0] vector,
  output logic              halted,
  output logic              fly_status
);
  logic int_hit, fly_hit;

  always_comb begin
    int_hit = accept && verdict.take && verdict.is_int;
    fly_hit = accept && verdict.take && verdict.is_fly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_taken  <= 1'b0;
      vector     <= '0;
      halted     <= 1'b0;
      fly_status <= 1'b0;
    end else begin
      sel_valid <= accept;
      sel_taken <= accept && verdict.take && !verdict.is_int && !verdict.is_fly;
      if (int_hit) vector <= addr;
      if (int_hit) halted <= 1'b1;
      else if (host_ptr_wr) halted <= 1'b0;
      if (fly_hit) fly_status <= 1'b1;
      else if (host_fly_clr) fly_status <= 1'b0;
    end
  end

  a_r5_result_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sel_valid);
  a_r6_int_halts: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |=> halted);
  a_r7_vector_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |=> (vector == $past(addr)));
  a_r7_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
    !int_hit |=> $stable(vector));
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ptr_wr && !int_hit) |=> !halted);
  a_r9_fly_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (fly_hit && !halted) |=> (fly_status && !halted));
  a_r10_fly_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (host_fly_clr && !fly_hit) |=> !fly_status);
endmodule

// File: rtl/script_branch_unit.sv
module script_branch_unit
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [WORD_W-1:0] instr_word,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic              carry,
  input  logic [PH_W-1:0]   phase_lat,
  input  logic [DAT_W-1:0]  data_lat,
  input  logic              initiator,
  input  logic              host_ptr_wr,
  input  logic              host_fly_clr,
  output logic              sel_valid,
  output logic              sel_taken,
  output logic              irq_n,
  output logic [ADDR_W-1:0] int_vector,
  output logic              halted,
  output logic              fly_status
);
  verdict_t verdict;
  logic     accept;

  assign instr_ready = !halted;
  assign accept      = instr_valid && instr_ready;
  assign irq_n       = !(halted || fly_status);

  sbu_cond_eval u_cond (
    .word      (instr_word),
    .carry     (carry),
    .phase_lat (phase_lat),
    .data_lat  (data_lat),
    .initiator (initiator),
    .verdict   (verdict)
  );

  sbu_int_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .verdict      (verdict),
    .addr         (instr_addr),
    .host_ptr_wr  (host_ptr_wr),
    .host_fly_clr (host_fly_clr),
    .sel_valid    (sel_valid),
    .sel_taken    (sel_taken),
    .vector       (int_vector),
    .halted       (halted),
    .fly_status   (fly_status)
  );

  a_r6_no_accept_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && instr_valid) |=> !sel_valid);
  a_r5_taken_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    sel_taken |-> sel_valid);
endmodule

// File: tb/script_branch_unit_bench.sv
module script_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr_word = '0;
  logic [31:0] instr_addr = '0;
  logic        carry = 1'b0;
  logic [2:0]  phase_lat = '0;
  logic [7:0]  data_lat = '0;
  logic        initiator = 1'b1;
  logic        host_ptr_wr = 1'b0;
  logic        host_fly_clr = 1'b0;
  logic        sel_valid, sel_taken, irq_n, halted, fly_status;
  logic [31:0] int_vector;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  script_branch_unit u_script_branch_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_word(instr_word), .instr_addr(instr_addr), .carry(carry),
    .phase_lat(phase_lat), .data_lat(data_lat), .initiator(initiator),
    .host_ptr_wr(host_ptr_wr), .host_fly_clr(host_fly_clr),
    .sel_valid(sel_valid), .sel_taken(sel_taken), .irq_n(irq_n),
    .int_vector(int_vector), .halted(halted), .fly_status(fly_status)
  );

  // reference model state
  bit          m_valid, m_taken, m_halt, m_fly;
  bit [31:0]   m_vec;
  string       m_tag = "R4";

  function automatic bit ref_take(input bit [31:0] w, input bit c, input bit [2:0] ph,
                                  input bit [7:0] d, input bit ini);
    bit m;
    if (w[21]) m = c;                                   // R1
    else begin
      m = 1'b1;                                         // R4
      if (w[17] && ini && (w[26:24] != ph)) m = 1'b0;   // R2
      if (w[18] && (w[7:0] != d)) m = 1'b0;             // R3
    end
    return w[19] ? m : !m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_taken = 0; m_halt = 0; m_fly = 0; m_vec = 0;
    end else begin
      bit acc, tk, is_i, is_f;
      acc  = instr_valid && !m_halt;
      tk   = ref_take(instr_word, carry, phase_lat, data_lat, initiator);
      is_i = instr_word[29:27] == 3'd3;
      is_f = instr_word[29:27] == 3'd4;
      m_valid = acc;
      m_taken = acc && tk && !is_i && !is_f;
      if (acc) m_tag = instr_word[21] ? "R1" : instr_word[17] ? "R2" :
                       instr_word[18] ? "R3" : "R4";
      if (acc && tk && is_i) begin m_vec = instr_addr; m_halt = 1; end
      else if (host_ptr_wr) m_halt = 0;
      if (acc && tk && is_f) m_fly = 1;
      else if (host_fly_clr) m_fly = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      // R12 reset state
      chk("R12 halted", {31'b0, halted}, 0);
      chk("R12 fly", {31'b0, fly_status}, 0);
      chk("R12 irq_n", {31'b0, irq_n}, 1);
      chk("R12 ready", {31'b0, instr_ready}, 1);
      chk("R12 vector", int_vector, 0);
      chk("R12 sel_valid", {31'b0, sel_valid}, 0);
    end else begin
      chk("R5 sel_valid", {31'b0, sel_valid}, {31'b0, m_valid});
      chk({m_tag, "/R5 sel_taken"}, {31'b0, sel_taken}, {31'b0, m_taken});
      chk("R6/R8 halted", {31'b0, halted}, {31'b0, m_halt});
      chk("R6/R8 ready", {31'b0, instr_ready}, {31'b0, !m_halt});
      chk("R7 vector", int_vector, m_vec);
      chk("R9/R10 fly", {31'b0, fly_status}, {31'b0, m_fly});
      chk("R11 irq_n", {31'b0, irq_n}, {31'b0, !(m_halt || m_fly)});
    end
  end

  function automatic bit [31:0] mk(input bit [2:0] op, input bit cry, input bit pol,
                                   input bit dce, input bit pce, input bit [2:0] ph,
                                   input bit [7:0] d);
    bit [31:0] w;
    w = '0;
    w[29:27] = op; w[26:24] = ph; w[21] = cry; w[19] = pol;
    w[18] = dce; w[17] = pce; w[7:0] = d;
    return w;
  endfunction

  task automatic drive(input bit [31:0] w, input bit [31:0] a, input bit c,
                       input bit [2:0] ph, input bit [7:0] d, input bit ini,
                       input bit v, input bit pw, input bit fc);
    @(negedge clk); #0.5;
    instr_word = w; instr_addr = a; carry = c; phase_lat = ph; data_lat = d;
    initiator = ini; instr_valid = v; host_ptr_wr = pw; host_fly_clr = fc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 carry test, both polarities
    drive(mk(3'd0,1,1,0,0,0,0), 0, 1, 0, 0, 1, 1, 0, 0);
    drive(mk(3'd0,1,1,1,1,5,8'h11), 0, 0, 2, 8'h22, 1, 1, 0, 0);
    drive(mk(3'd0,1,0,0,0,0,0), 0, 0, 0, 0, 1, 1, 0, 0);
    // R2 phase match / mismatch / target mode ignores phase
    drive(mk(3'd0,0,1,0,1,3'd6,0), 0, 0, 3'd6, 0, 1, 1, 0, 0);
    drive(mk(3'd0,0,1,0,1,3'd6,0), 0, 0, 3'd1, 0, 1, 1, 0, 0);
    drive(mk(3'd0,0,1,0,1,3'd6,0), 0, 0, 3'd1, 0, 0, 1, 0, 0);
    // R3 data and combined compares
    drive(mk(3'd0,0,1,1,0,0,8'hA5), 0, 0, 0, 8'hA5, 1, 1, 0, 0);
    drive(mk(3'd0,0,1,1,1,3'd2,8'hA5), 0, 0, 3'd3, 8'hA5, 1, 1, 0, 0);
    drive(mk(3'd0,0,0,1,1,3'd2,8'hA5), 0, 0, 3'd3, 8'hA5, 1, 1, 0, 0);
    // R4 unconditional
    drive(mk(3'd0,0,1,0,0,0,0), 0, 0, 0, 0, 1, 1, 0, 0);
    drive(mk(3'd0,0,0,0,0,0,0), 0, 0, 0, 0, 1, 1, 0, 0);
    // R9 fly, then R10 set-over-clear, then clear
    drive(mk(3'd4,0,1,0,0,0,0), 32'h55, 0, 0, 0, 1, 1, 0, 0);
    drive(mk(3'd4,0,1,0,0,0,0), 32'h56, 0, 0, 0, 1, 1, 0, 1);
    drive(mk(3'd0,0,1,0,0,0,0), 0, 0, 0, 0, 1, 0, 0, 1);
    // R6/R7 halting interrupt, ignored instructions, R8 release
    drive(mk(3'd3,0,1,0,0,0,0), 32'hCAFE_0123, 0, 0, 0, 1, 1, 0, 0);
    drive(mk(3'd3,0,1,0,0,0,0), 32'h1111_2222, 0, 0, 0, 1, 1, 0, 0);
    drive(mk(3'd0,0,1,0,0,0,0), 0, 0, 0, 0, 1, 1, 0, 0);
    drive(mk(3'd0,0,1,0,0,0,0), 0, 0, 0, 0, 1, 0, 1, 0);
    drive(mk(3'd0,0,1,0,0,0,0), 0, 0, 0, 0, 1, 1, 0, 0);
    // non-taken interrupt keeps vector
    drive(mk(3'd3,0,0,0,0,0,0), 32'hDEAD_BEEF, 0, 0, 0, 1, 1, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] w; bit [2:0] ph; bit [7:0] d; int sel;
      w = $urandom; sel = $urandom_range(0, 3);
      w[29:27] = (sel == 0) ? 3'd3 : (sel == 1) ? 3'd4 : 3'($urandom_range(0, 2));
      ph = ($urandom_range(0, 1) == 1) ? w[26:24] : 3'($urandom);
      d  = ($urandom_range(0, 1) == 1) ? w[7:0] : 8'($urandom);
      drive(w, $urandom, 1'($urandom), ph, d, 1'($urandom),
            $urandom_range(0, 3) != 0, halted && ($urandom_range(0, 2) == 0),
            $urandom_range(0, 7) == 0);
    end
    drive(0, 0, 0, 0, 0, 1, 0, 1, 1);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule